// File: doc/BRIEF.md
# Two-Level Subroutine Return Stack

This block holds subroutine return addresses for an instruction sequencer. It is a last-in-first-out store two levels deep with 12-bit entries. On a call, the sequencer pulses a push strobe and presents the return address, which is the current counter plus one. On a return, it pulses a pop strobe. The newest entry is always visible on a combinational top-of-stack output. Because of this, the sequencer can load its counter from that output in the same cycle that it issues the pop.

The stack never reports overflow or underflow. When a push arrives with both levels full, the deepest entry is dropped. A pop copies the deepest level upward and leaves the deepest level as it was. As a result, a run of returns longer than the stack keeps producing the same address.

Reset does not clear the stored addresses. While reset is held, both strobes are ignored. The depth is a parameter with a default of two. With a larger value, the design builds a longer chain of levels that follows the same rules.

Top module: `retstack2`

## Requirements
- R1: `tos_o` shows level 1 combinationally. A pop strobe held during a cycle does not change `tos_o` before the next rising clock edge.
- R2: A push with reset released loads `push_addr_i` into level 1 at the rising edge, so `tos_o` equals that address in the next cycle.
- R3: A push moves the old level 1 value into level 2 at the same edge. A later pop therefore returns the address that was on top before the push.
- R4: After three or more pushes in a row, only the two newest addresses are kept. Pushing A, B, C and then popping three times gives C, B, B.
- R5: A pop (push low) loads level 2 into level 1 and leaves level 2 unchanged.
- R6: Every pop after the stack has emptied returns the level 2 address again. The stack has no underflow indication.
- R7: When push and pop are both high in one cycle, the push wins. The new address goes to level 1, the old level 1 goes to level 2, and no pop takes place.
- R8: While `rst_n` is low, push and pop have no effect. The stored addresses are kept through reset and are not cleared by it.
- R9: In a cycle with neither strobe high, both levels hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; blocks both strobes and keeps the stored contents |
| push_i | input | 1 | Call strobe: push `push_addr_i` |
| push_addr_i | input | ADDR_W (12) | Return address to store |
| pop_i | input | 1 | Return strobe: pop the top entry |
| tos_o | output | ADDR_W (12) | Current level 1 (top-of-stack) value |

## Verification
The checker tests the effect of each strobe on every clock edge. A push must place its address on top and move the old top down (R2, R3, R7). A pop must raise level 2 into level 1 and keep level 2 fixed (R5). An idle cycle must hold both levels (R9). Some behaviours only show up over a sequence of operations, and only the bench scenarios reveal them. These are the loss of the oldest entry after a run of calls (R4), the same address repeating across a run of returns (R6), and contents surviving a reset pulse during which the strobes were toggled (R8). The bench also samples `tos_o` mid-cycle while a pop is held, which shows that the output is combinational (R1).

// File: rtl/retstack2_pkg.sv
package retstack2_pkg;
   // Operation applied to the level chain in one cycle.
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_PUSH = 2'd1,
      RS_POP  = 2'd2
   } rs_op_e;
endpackage

// File: rtl/retstack2_ctrl.sv
module retstack2_ctrl
   import retstack2_pkg::*;
(
   input  logic   rst_n,
   input  logic   push_i,
   input  logic   pop_i,
   output rs_op_e op_o
);
   // Push outranks pop; reset blocks both strobes.
   always_comb begin
      op_o = RS_IDLE;
      if (rst_n) begin
         if (push_i)
            op_o = RS_PUSH;
         else if (pop_i)
            op_o = RS_POP;
      end
   end
endmodule

// File: rtl/retstack2_level.sv
module retstack2_level
   import retstack2_pkg::*;
#(
   parameter int ADDR_W = 12,
   // Deepest level keeps its value on pop.
   parameter bit BOTTOM = 1'b0
) (
   input  logic              clk,
   input  rs_op_e            op_i,
   input  logic [ADDR_W-1:0] from_above_i,
   input  logic [ADDR_W-1:0] from_below_i,
   output logic [ADDR_W-1:0] q_o
);
   logic              load;
   logic [ADDR_W-1:0] nxt;

   generate
      if (BOTTOM) begin : g_bottom
         assign load = (op_i == RS_PUSH);
         assign nxt  = from_above_i;
         logic unused_below;
         assign unused_below = ^from_below_i;
      end else begin : g_inner
         assign load = (op_i == RS_PUSH) || (op_i == RS_POP);
         assign nxt  = (op_i == RS_PUSH) ? from_above_i : from_below_i;
      end
   endgenerate

   // Contents are not reset.
   always_ff @(posedge clk) begin
      if (load)
         q_o <= nxt;
   end
endmodule

// File: rtl/retstack2.sv
module retstack2
   import retstack2_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic              pop_i,
   output logic [ADDR_W-1:0] tos_o
);
   localparam int LAST = DEPTH - 1;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("retstack2: ADDR_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("retstack2: DEPTH must be at least 2");
      end
   endgenerate

   rs_op_e            op;
   logic [ADDR_W-1:0] lvl_q [DEPTH];

   retstack2_ctrl u_ctrl (
      .rst_n  (rst_n),
      .push_i (push_i),
      .pop_i  (pop_i),
      .op_o   (op)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
         logic [ADDR_W-1:0] above;
         logic [ADDR_W-1:0] below;
         if (i == 0) begin : g_top
            assign above = push_addr_i;
         end else begin : g_mid_above
            assign above = lvl_q[i-1];
         end
         if (i == LAST) begin : g_last
            assign below = lvl_q[i];
         end else begin : g_mid_below
            assign below = lvl_q[i+1];
         end
         retstack2_level #(
            .ADDR_W (ADDR_W),
            .BOTTOM (i == LAST)
         ) u_level (
            .clk          (clk),
            .op_i         (op),
            .from_above_i (above),
            .from_below_i (below),
            .q_o          (lvl_q[i])
         );
      end
   endgenerate

   assign tos_o = lvl_q[0];
endmodule

// File: rtl/retstack2_chk.sv
module retstack2_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic [ADDR_W-1:0] push_addr_i,
   input logic              pop_i,
   input logic [ADDR_W-1:0] tos_o,
   input logic [ADDR_W-1:0] nxt_q,
   input logic [ADDR_W-1:0] bot_q
);
   // R2 R7
   push_loads_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> tos_o == $past(push_addr_i));

   // R3
   push_shifts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> nxt_q == $past(tos_o));

   // R5
   pop_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> tos_o == $past(nxt_q));

   // R5
   pop_keeps_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> bot_q == $past(bot_q));

   // R9
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_i && !push_i) |=> (tos_o == $past(tos_o)) && (bot_q == $past(bot_q)));
endmodule

bind retstack2 retstack2_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .push_addr_i (push_addr_i),
   .pop_i       (pop_i),
   .tos_o       (tos_o),
   .nxt_q       (lvl_q[1]),
   .bot_q       (lvl_q[DEPTH-1])
);

// File: tb/retstack2_bench.sv
module retstack2_bench;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push = 1'b0;
   logic          pop = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [AW-1:0] tos;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   retstack2 #(.ADDR_W(AW), .DEPTH(2)) u_retstack2 (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_addr_i (addr),
      .pop_i       (pop),
      .tos_o       (tos)
   );

   task automatic check(input string req, input logic [AW-1:0] exp);
      checks++;
      if (tos !== exp) begin
         errors++;
         $display("FAIL %s: tos=%03h expected %03h", req, tos, exp);
      end
   endtask

   // Drive on the falling edge, let one rising edge act, return at the next falling edge.
   task automatic step(input logic p, input logic q, input logic [AW-1:0] a);
      push = p; pop = q; addr = a;
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
   endtask

   task automatic t_push_pop();
      step(1, 0, 12'h123);
      check("R2", 12'h123);
      step(1, 0, 12'h456);
      check("R2", 12'h456);
      step(0, 0, 12'h000);
      check("R9", 12'h456);
      step(0, 1, 12'h000);
      check("R3", 12'h123);
   endtask

   task automatic t_comb_out();
      step(1, 0, 12'h0A5);
      step(1, 0, 12'h05A);
      pop = 1'b1;
      #3;
      check("R1", 12'h05A);
      @(negedge clk);
      pop = 1'b0;
      check("R5", 12'h0A5);
   endtask

   task automatic t_overflow();
      step(1, 0, 12'hAAA);
      step(1, 0, 12'hBBB);
      step(1, 0, 12'hCCC);
      check("R4", 12'hCCC);
      step(0, 1, 12'h000);
      check("R4", 12'hBBB);
      step(0, 1, 12'h000);
      check("R4", 12'hBBB);
   endtask

   task automatic t_underflow();
      step(1, 0, 12'h111);
      step(1, 0, 12'h222);
      step(0, 1, 12'h000);
      check("R5", 12'h111);
      step(0, 1, 12'h000);
      check("R6", 12'h111);
      step(0, 1, 12'h000);
      check("R6", 12'h111);
      step(0, 1, 12'h000);
      check("R6", 12'h111);
   endtask

   task automatic t_collision();
      step(1, 0, 12'h301);
      step(1, 0, 12'h302);
      step(1, 1, 12'h303);
      check("R7", 12'h303);
      step(0, 1, 12'h000);
      check("R7", 12'h302);
   endtask

   task automatic t_reset_hold();
      step(1, 0, 12'h7E1);
      step(1, 0, 12'h7E2);
      rst_n = 1'b0;
      step(1, 0, 12'hFFF);
      check("R8", 12'h7E2);
      step(0, 1, 12'h000);
      check("R8", 12'h7E2);
      rst_n = 1'b1;
      step(0, 0, 12'h000);
      check("R8", 12'h7E2);
      step(0, 1, 12'h000);
      check("R8", 12'h7E1);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_push_pop();
      t_comb_out();
      t_overflow();
      t_underflow();
      t_collision();
      t_reset_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule